// File: doc/BRIEF.md
# Frame-Paced Isochronous Buffer Manager

This block keeps the buffer state for a set of isochronous transmit (IN) endpoints and a set of isochronous receive (OUT) endpoints. Buffer turnover follows a periodic one-cycle frame pulse rather than any per-packet handshake. On the transmit side, software marks a buffer ready with a validate strobe that carries the packet length. At each frame pulse, every transmit endpoint is armed for the new frame. It either sends its stored packet, if it was validated in time, or a zero-length packet if it was not. The serial engine reads the arm flag and the send length, and reports completion with a sent strobe.

On the receive side, each arriving packet is always accepted, whether or not software has freed the buffer. Data still unread when the frame pulse arrives is discarded. Sticky flags record that a packet overwrote unread data, and that unread data was dropped at a frame end. Endpoints are picked by index on shared strobe buses. All outputs are registered and change one clock after the strobe that causes them.

Top module: `iso_frame_buf`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is 0.
- R2: A validate strobe with index e and length L, followed later by a frame pulse, gives tx_arm[e]=1 and send length L in the cycle after the pulse. The length of endpoint e sits in tx_len bits [e*LEN_W +: LEN_W].
- R3: A frame pulse on an endpoint with no pending validation gives tx_arm[e]=0 and a send length of 0, which is a zero-length packet.
- R4: A frame pulse consumes the pending validation, so in_pending[e] reads 0 afterwards. A second frame with no new validate gives a zero-length packet.
- R5: A validate in the same cycle as a frame pulse does not count for that frame. It leaves in_pending[e]=1 and is sent at the following frame.
- R6: A sent strobe for endpoint e clears tx_arm[e] and its send length to 0. If a frame pulse falls in the same cycle, the frame result wins.
- R7: A receive strobe with index e and length L always sets out_full[e]=1 and out_len to L, in bits [e*LEN_W +: LEN_W]. If the buffer was still full, with no clear and no frame pulse in that cycle, out_ovr[e] sets.
- R8: A clear strobe sets out_full[e]=0 and out_len to 0. A clear together with a receive leaves the new packet stored and sets no overrun.
- R9: A frame pulse on a full buffer that is not cleared in that cycle drops the data and sets out_drop[e]. A receive in the same cycle stores the new packet after the drop.
- R10: out_ovr and out_drop stay set until reset, and strobes for other endpoints leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | One-cycle frame boundary event |
| val_stb | input | 1 | Validate a transmit buffer |
| val_ep | input | IN_IW | Transmit endpoint index for validate |
| val_len | input | LEN_W | Length of the validated packet |
| sent_stb | input | 1 | Serial engine finished sending |
| sent_ep | input | IN_IW | Transmit endpoint index for sent |
| rx_stb | input | 1 | Packet received from the serial side |
| rx_ep | input | OUT_IW | Receive endpoint index |
| rx_len | input | LEN_W | Received packet length |
| clr_stb | input | 1 | Clear (free) a receive buffer |
| clr_ep | input | OUT_IW | Receive endpoint index for clear |
| tx_arm | output | N_IN | Stored packet selected for this frame |
| tx_len | output | N_IN*LEN_W | Send length per transmit endpoint (0 = empty packet) |
| in_pending | output | N_IN | Validated and waiting for the next frame |
| out_full | output | N_OUT | Receive buffer holds unread data |
| out_len | output | N_OUT*LEN_W | Length of the held packet |
| out_ovr | output | N_OUT | Sticky: unread data overwritten |
| out_drop | output | N_OUT | Sticky: unread data dropped at frame end |

## Verification
Two pairs of events can coincide: a validate with the frame pulse on the transmit side, and a receive with the frame pulse (or with a clear) on the receive side. Directed cases place these strobes in the same cycle on purpose. Random runs then raise each strobe with a fixed chance per cycle, so coincidences happen often on both endpoints. After every edge, a bench model computed from the requirements judges the outcome. It expects the validate to be deferred to the next frame, and the received packet to survive the drop of the older data without an overrun being flagged.

// File: rtl/iso_pkg.sv
package iso_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/iso_in_slot.sv
module iso_in_slot #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame,
  input  logic             val_hit,
  input  logic [LEN_W-1:0] val_len,
  input  logic             sent_hit,
  output logic             arm,
  output logic [LEN_W-1:0] len,
  output logic             pending
);
  logic             pend_q, pend_d;
  logic [LEN_W-1:0] vlen_q, vlen_d;
  logic             arm_q, arm_d;
  logic [LEN_W-1:0] tlen_q, tlen_d;
  logic             en;

  assign en = frame | val_hit | sent_hit;

  always_comb begin
    pend_d = frame ? val_hit : (pend_q | val_hit);
    vlen_d = val_hit ? val_len : vlen_q;
    arm_d  = arm_q;
    tlen_d = tlen_q;
    if (frame) begin
      arm_d  = pend_q;
      tlen_d = pend_q ? vlen_q : '0;
    end else if (sent_hit) begin
      arm_d  = 1'b0;
      tlen_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vlen_q <= '0;
      arm_q  <= 1'b0;
      tlen_q <= '0;
    end else if (en) begin
      pend_q <= pend_d;
      vlen_q <= vlen_d;
      arm_q  <= arm_d;
      tlen_q <= tlen_d;
    end
  end

  assign arm     = arm_q;
  assign len     = tlen_q;
  assign pending = pend_q;

  assert_arm_follows_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame |=> (arm == $past(pend_q)));
  assert_empty_when_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |-> (len == '0));
  assert_frame_consumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !val_hit) |=> !pending);
  assert_defer_to_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && val_hit) |=> pending);
  assert_sent_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_hit && !frame) |=> !arm);
endmodule

// File: rtl/iso_out_slot.sv
module iso_out_slot #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame,
  input  logic             rx_hit,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             clr_hit,
  output logic             full,
  output logic [LEN_W-1:0] len,
  output logic             ovr,
  output logic             drop
);
  logic             full_q, full_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             ovr_q, ovr_d;
  logic             drop_q, drop_d;
  logic             en;

  assign en = frame | rx_hit | clr_hit;

  always_comb begin
    if (rx_hit) begin
      full_d = 1'b1;
      len_d  = rx_len;
    end else if (clr_hit || frame) begin
      full_d = 1'b0;
      len_d  = '0;
    end else begin
      full_d = full_q;
      len_d  = len_q;
    end
    ovr_d  = ovr_q  | (rx_hit & full_q & ~clr_hit & ~frame);
    drop_d = drop_q | (frame & full_q & ~clr_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      len_q  <= '0;
      ovr_q  <= 1'b0;
      drop_q <= 1'b0;
    end else if (en) begin
      full_q <= full_d;
      len_q  <= len_d;
      ovr_q  <= ovr_d;
      drop_q <= drop_d;
    end
  end

  assign full = full_q;
  assign len  = len_q;
  assign ovr  = ovr_q;
  assign drop = drop_q;

  assert_rx_always_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit |=> full);
  assert_overwrite_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && full && !clr_hit && !frame) |=> ovr);
  assert_clear_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !rx_hit) |=> !full);
  assert_frame_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && full && !clr_hit && !rx_hit) |=> (!full && drop));
  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);
  assert_drop_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> drop);
endmodule

// File: rtl/iso_frame_buf.sv
module iso_frame_buf
  import iso_pkg::*;
#(
  parameter int N_IN   = 2,
  parameter int N_OUT  = 2,
  parameter int LEN_W  = 10,
  localparam int IN_IW  = idx_w(N_IN),
  localparam int OUT_IW = idx_w(N_OUT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_pulse,
  input  logic                   val_stb,
  input  logic [IN_IW-1:0]       val_ep,
  input  logic [LEN_W-1:0]       val_len,
  input  logic                   sent_stb,
  input  logic [IN_IW-1:0]       sent_ep,
  input  logic                   rx_stb,
  input  logic [OUT_IW-1:0]      rx_ep,
  input  logic [LEN_W-1:0]       rx_len,
  input  logic                   clr_stb,
  input  logic [OUT_IW-1:0]      clr_ep,
  output logic [N_IN-1:0]        tx_arm,
  output logic [N_IN*LEN_W-1:0]  tx_len,
  output logic [N_IN-1:0]        in_pending,
  output logic [N_OUT-1:0]       out_full,
  output logic [N_OUT*LEN_W-1:0] out_len,
  output logic [N_OUT-1:0]       out_ovr,
  output logic [N_OUT-1:0]       out_drop
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
    logic vhit, shit;
    assign vhit = val_stb  && (val_ep  == IN_IW'(gi));
    assign shit = sent_stb && (sent_ep == IN_IW'(gi));
    iso_in_slot #(.LEN_W(LEN_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_sync),
      .frame    (frame_pulse),
      .val_hit  (vhit),
      .val_len  (val_len),
      .sent_hit (shit),
      .arm      (tx_arm[gi]),
      .len      (tx_len[gi*LEN_W +: LEN_W]),
      .pending  (in_pending[gi])
    );
  end

  for (genvar go = 0; go < N_OUT; go++) begin : g_out
    logic rhit, chit;
    assign rhit = rx_stb  && (rx_ep  == OUT_IW'(go));
    assign chit = clr_stb && (clr_ep == OUT_IW'(go));
    iso_out_slot #(.LEN_W(LEN_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_sync),
      .frame   (frame_pulse),
      .rx_hit  (rhit),
      .rx_len  (rx_len),
      .clr_hit (chit),
      .full    (out_full[go]),
      .len     (out_len[go*LEN_W +: LEN_W]),
      .ovr     (out_ovr[go]),
      .drop    (out_drop[go])
    );
  end

  assert_idle_after_release_R1: assert property (@(posedge clk)
    ($rose(rst_sync)) |-> (tx_arm == '0 && out_full == '0 && out_ovr == '0 && out_drop == '0));
endmodule

// File: tb/test_iso_frame_buf.sv
`timescale 1ns/1ps
module test_iso_frame_buf;
  localparam int NI = 2, NO = 2, LW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_pulse, val_stb, sent_stb, rx_stb, clr_stb;
  logic [0:0] val_ep, sent_ep, rx_ep, clr_ep;
  logic [LW-1:0] val_len, rx_len;
  logic [NI-1:0] tx_arm, in_pending;
  logic [NI*LW-1:0] tx_len;
  logic [NO-1:0] out_full, out_ovr, out_drop;
  logic [NO*LW-1:0] out_len;

  always #2.5 clk = ~clk;

  iso_frame_buf #(.N_IN(NI), .N_OUT(NO), .LEN_W(LW)) i_iso_frame_buf (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .val_stb(val_stb), .val_ep(val_ep), .val_len(val_len),
    .sent_stb(sent_stb), .sent_ep(sent_ep),
    .rx_stb(rx_stb), .rx_ep(rx_ep), .rx_len(rx_len),
    .clr_stb(clr_stb), .clr_ep(clr_ep),
    .tx_arm(tx_arm), .tx_len(tx_len), .in_pending(in_pending),
    .out_full(out_full), .out_len(out_len), .out_ovr(out_ovr), .out_drop(out_drop));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [NI-1:0] m_pend, m_arm;
  logic [LW-1:0] m_vlen [NI];
  logic [LW-1:0] m_tlen [NI];
  logic [NO-1:0] m_full, m_ovr, m_drop;
  logic [LW-1:0] m_olen [NO];

  function automatic void model_reset();
    m_pend = '0; m_arm = '0; m_full = '0; m_ovr = '0; m_drop = '0;
    for (int i = 0; i < NI; i++) begin m_vlen[i] = '0; m_tlen[i] = '0; end
    for (int i = 0; i < NO; i++) m_olen[i] = '0;
  endfunction

  function automatic void model_step();
    for (int i = 0; i < NI; i++) begin
      bit v = val_stb && (val_ep == i[0:0]);
      bit s = sent_stb && (sent_ep == i[0:0]);
      if (frame_pulse) begin
        m_arm[i]  = m_pend[i];
        m_tlen[i] = m_pend[i] ? m_vlen[i] : '0;
      end else if (s) begin
        m_arm[i] = 1'b0; m_tlen[i] = '0;
      end
      m_pend[i] = frame_pulse ? v : (m_pend[i] | v);
      if (v) m_vlen[i] = val_len;
    end
    for (int i = 0; i < NO; i++) begin
      bit r = rx_stb && (rx_ep == i[0:0]);
      bit c = clr_stb && (clr_ep == i[0:0]);
      if (r && m_full[i] && !c && !frame_pulse) m_ovr[i] = 1'b1;
      if (frame_pulse && m_full[i] && !c) m_drop[i] = 1'b1;
      if (r) begin m_full[i] = 1'b1; m_olen[i] = rx_len; end
      else if (c || frame_pulse) begin m_full[i] = 1'b0; m_olen[i] = '0; end
    end
  endfunction

  task automatic check(input string req);
    logic [NI*LW-1:0] etx;
    logic [NO*LW-1:0] eol;
    for (int i = 0; i < NI; i++) etx[i*LW +: LW] = m_tlen[i];
    for (int i = 0; i < NO; i++) eol[i*LW +: LW] = m_olen[i];
    n_chk++;
    if (tx_arm !== m_arm || tx_len !== etx || in_pending !== m_pend ||
        out_full !== m_full || out_len !== eol || out_ovr !== m_ovr || out_drop !== m_drop) begin
      n_fail++;
      $display("FAIL %s: actual arm=%b len=%h pend=%b full=%b olen=%h ovr=%b drop=%b expected arm=%b len=%h pend=%b full=%b olen=%h ovr=%b drop=%b",
        req, tx_arm, tx_len, in_pending, out_full, out_len, out_ovr, out_drop,
        m_arm, etx, m_pend, m_full, eol, m_ovr, m_drop);
    end
  endtask

  task automatic idle();
    frame_pulse = 0; val_stb = 0; sent_stb = 0; rx_stb = 0; clr_stb = 0;
    val_ep = 0; sent_ep = 0; rx_ep = 0; clr_ep = 0; val_len = 0; rx_len = 0;
  endtask

  task automatic step(input string req);
    model_step();
    @(posedge clk); #1;
    check(req);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0; model_reset();
    repeat (2) @(posedge clk); #1;
    check("R1 during reset");
    rst_n = 1;
    repeat (2) @(posedge clk); #1;
    check("R1 after release");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL R1-watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R3: frame with nothing validated -> empty packet
    frame_pulse = 1; step("R3 empty frame");
    // R2: validate ep1 len 300 then frame
    val_stb = 1; val_ep = 1; val_len = 10'd300; step("R2 validate");
    frame_pulse = 1; step("R2 armed");
    // R4: next frame with no validate -> empty
    frame_pulse = 1; step("R4 consumed");
    // R5: validate same cycle as frame
    frame_pulse = 1; val_stb = 1; val_ep = 0; val_len = 10'd17; step("R5 coincident");
    frame_pulse = 1; step("R5 sent next frame");
    // R6: sent clears arm
    sent_stb = 1; sent_ep = 0; step("R6 sent");
    val_stb = 1; val_ep = 0; val_len = 10'd5; step("R6 prep");
    frame_pulse = 1; sent_stb = 1; sent_ep = 0; step("R6 frame wins");
    // R7: receive, then overwrite
    rx_stb = 1; rx_ep = 0; rx_len = 10'd64; step("R7 receive");
    rx_stb = 1; rx_ep = 0; rx_len = 10'd65; step("R7 overrun");
    // R8: clear with receive, then clear alone
    rx_stb = 1; rx_ep = 0; rx_len = 10'd66; clr_stb = 1; clr_ep = 0; step("R8 clear+rx");
    clr_stb = 1; clr_ep = 0; step("R8 clear");
    // R9: frame drops unread data on ep1, with rx in same cycle
    rx_stb = 1; rx_ep = 1; rx_len = 10'd9; step("R9 fill");
    frame_pulse = 1; rx_stb = 1; rx_ep = 1; rx_len = 10'd11; step("R9 drop+rx");
    frame_pulse = 1; step("R9 drop");
    // R10: sticky flags survive other traffic
    rx_stb = 1; rx_ep = 0; rx_len = 10'd3; step("R10 sticky");
    clr_stb = 1; clr_ep = 1; step("R10 sticky");
    // random phase
    for (int k = 0; k < 4000; k++) begin
      frame_pulse = ($urandom_range(0, 7) == 0);
      val_stb  = ($urandom_range(0, 2) == 0); val_ep  = 1'($urandom_range(0, 1));
      val_len  = LW'($urandom_range(0, 1023));
      sent_stb = ($urandom_range(0, 3) == 0); sent_ep = 1'($urandom_range(0, 1));
      rx_stb   = ($urandom_range(0, 2) == 0); rx_ep   = 1'($urandom_range(0, 1));
      rx_len   = LW'($urandom_range(0, 1023));
      clr_stb  = ($urandom_range(0, 3) == 0); clr_ep  = 1'($urandom_range(0, 1));
      step("R2-R10 random");
      if (k == 2000) do_reset();
    end
    do_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F0C));
  end
endmodule